// File: doc/BRIEF.md
# Paged Receive Buffer Packet Writer

This block takes an incoming packet as a stream of bytes, framed by start and end markers, and stores it in one page of a receive RAM. The host picks the page. Each stored packet starts with a fixed header: the sender's node ID, the addressed node ID, and then a count byte. The count byte tells short packets apart from long ones. The message bytes are placed so that the last one lands on the final header-relative offset of its region. The first one lands at the offset that the count byte names.

A receive-inhibit flag is set when a packet has been stored completely. The flag drives an interrupt when the host's mask bit allows it. While the flag is set, arriving packets are turned away. To re-arm the block, the host issues an enable-receive command that carries a page index. The command clears the flag and selects the page for the next packet. A configuration input allows long packets. When it is set, pages grow from 256 to 512 bytes.

Top module: `rx_page_writer`

## Requirements
- R1: A correctly framed packet that is accepted sets `ri_flag` to 1 on the clock edge that takes its final byte. `rx_irq` is 1 exactly when `ri_flag` is 1 and `irq_mask` is 1.
- R2: After reset, `ri_flag` is 1 and the page index is 0. A pulse on `cmd_en` clears `ri_flag` to 0 and stores `cmd_page` as the page for the next packet.
- R3: Stream byte 0 (the source ID) is written at page offset 0, byte 1 (the destination ID) at offset 1, and byte 2 (the first count byte) at offset 2. Each RAM write appears on the cycle after its byte is taken.
- R4: A short packet has a nonzero first count byte C = 256−N. Its N message bytes go to offsets C through 255, in order. If C is below 3, the packet is discarded: nothing from offset 2 onward is written and `ri_flag` stays 0.
- R5: A long packet has a first count byte of 0 and a second count byte D = 512−N, written at offset 3. Its message bytes go to offsets D through 511. A long packet is accepted only while `cfg_long_en` is 1, and only if D is at least 4. Otherwise the block writes nothing after offset 1 (for the enable case) or offset 2 (for the D case), and `ri_flag` stays 0.
- R6: The RAM address is page × 256 + offset when `cfg_long_en` is 0, and page × 512 + offset when it is 1, taken modulo the RAM size.
- R7: While `ri_flag` is 1, an arriving packet produces no RAM write and leaves `ri_flag` at 1.
- R8: If the end marker arrives before the last offset of the region is written, or if further bytes follow that last byte, the packet is not completed and `ri_flag` stays 0. Bytes past the last offset are not written.
- R9: The page index and page size in force at a packet's start byte apply to the whole packet. A command issued partway through a packet does not move that packet.
- R10: When a command and a packet's completing byte fall in the same cycle, completion wins and `ri_flag` ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Stream byte present this cycle |
| in_sop | input | 1 | Byte is the first of a packet |
| in_eop | input | 1 | Byte is the last of a packet |
| in_data | input | 8 | Stream byte |
| cfg_long_en | input | 1 | Allow long packets; selects 512-byte pages |
| irq_mask | input | 1 | Interrupt enable for the receive-inhibit flag |
| cmd_en | input | 1 | Enable-receive command strobe |
| cmd_page | input | PAGE_W | Page index carried by the command |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| ri_flag | output | 1 | Receive-inhibit flag |
| rx_irq | output | 1 | Interrupt request |

## Verification
The host's re-arm command and the completion of a packet can land on the same clock edge. One of them clears the receive-inhibit flag and the other sets it. The bench provokes this by pulsing the command together with the final byte of a packet. It then judges the outcome by requiring the flag and the interrupt to read 1 afterwards. A second overlap, a command arriving in the middle of a packet, is provoked the same way on an inner byte. It is judged by finding the whole packet in the page that was selected before the command.

// File: rtl/rx_page_writer.sv
module rx_page_writer #(
  parameter int PAGE_W = 3,
  parameter int RAM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic              cfg_long_en,
  input  logic              irq_mask,
  input  logic              cmd_en,
  input  logic [PAGE_W-1:0] cmd_page,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ri_flag,
  output logic              rx_irq
);
  localparam int FW = PAGE_W + 9;

  typedef enum logic [2:0] {S_IDLE, S_DID, S_CNT1, S_CNT2, S_DATA, S_DROP} st_t;

  st_t               st, nxt;
  logic [PAGE_W-1:0] page_q, pkt_page, sel_page;
  logic              pkt_cfg, sel_cfg, long_pkt, lp_n;
  logic [8:0]        ptr, ptr_n, off, last_off;
  logic              wr, fin;
  logic [FW-1:0]     full;

  assign last_off = long_pkt ? 9'd511 : 9'd255;
  assign sel_page = (st == S_IDLE) ? page_q : pkt_page;
  assign sel_cfg  = (st == S_IDLE) ? cfg_long_en : pkt_cfg;
  assign full     = sel_cfg ? {sel_page, off} : {1'b0, sel_page, off[7:0]};
  assign rx_irq   = ri_flag & irq_mask;

  always_comb begin
    nxt   = st;
    wr    = 1'b0;
    off   = '0;
    fin   = 1'b0;
    ptr_n = ptr;
    lp_n  = long_pkt;
    if (in_valid) begin
      case (st)
        S_IDLE: if (in_sop) begin
          if (ri_flag || in_eop) nxt = in_eop ? S_IDLE : S_DROP;
          else begin wr = 1'b1; off = 9'd0; nxt = S_DID; end
        end
        S_DID: begin
          wr = 1'b1; off = 9'd1;
          nxt = in_eop ? S_IDLE : S_CNT1;
        end
        S_CNT1: begin
          if (in_eop) nxt = S_IDLE;
          else if (in_data == 8'd0) begin
            if (pkt_cfg) begin wr = 1'b1; off = 9'd2; nxt = S_CNT2; end
            else nxt = S_DROP;
          end else if (in_data < 8'd3) nxt = S_DROP;
          else begin
            wr = 1'b1; off = 9'd2; lp_n = 1'b0;
            ptr_n = {1'b0, in_data}; nxt = S_DATA;
          end
        end
        S_CNT2: begin
          if (in_eop) nxt = S_IDLE;
          else if (in_data < 8'd4) nxt = S_DROP;
          else begin
            wr = 1'b1; off = 9'd3; lp_n = 1'b1;
            ptr_n = {1'b0, in_data}; nxt = S_DATA;
          end
        end
        S_DATA: begin
          wr = 1'b1; off = ptr;
          if (ptr == last_off) begin
            if (in_eop) begin fin = 1'b1; nxt = S_IDLE; end
            else nxt = S_DROP;
          end else begin
            ptr_n = ptr + 9'd1;
            if (in_eop) nxt = S_IDLE;
          end
        end
        S_DROP: if (in_eop) nxt = S_IDLE;
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      page_q   <= '0;
      pkt_page <= '0;
      pkt_cfg  <= 1'b0;
      long_pkt <= 1'b0;
      ptr      <= '0;
      ri_flag  <= 1'b1;
      ram_we   <= 1'b0;
      ram_addr <= '0;
      ram_wdata <= '0;
    end else begin
      st       <= nxt;
      ptr      <= ptr_n;
      long_pkt <= lp_n;
      if (st == S_IDLE && in_valid && in_sop) begin
        pkt_page <= page_q;
        pkt_cfg  <= cfg_long_en;
      end
      if (cmd_en) page_q <= cmd_page;
      if (fin) ri_flag <= 1'b1;
      else if (cmd_en) ri_flag <= 1'b0;
      ram_we    <= wr;
      ram_addr  <= RAM_AW'(full);
      ram_wdata <= in_data;
    end
  end
endmodule

module rx_page_writer_chk #(
  parameter int PAGE_W = 3,
  parameter int RAM_AW = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_eop,
  input logic              irq_mask,
  input logic              cmd_en,
  input logic              ram_we,
  input logic              ri_flag,
  input logic              rx_irq
);
  AST_RI_SET_BY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_flag) |-> $past(in_valid && in_eop)); // R1
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (irq_mask && ri_flag)); // R1
  AST_CMD_CLEARS_RI: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !(in_valid && in_eop)) |=> !ri_flag); // R2
  AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(in_valid)); // R3
  AST_RI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_flag && !cmd_en) |=> ri_flag); // R7
  AST_NO_WRITE_INHIBITED: assert property (@(posedge clk) disable iff (!rst_n)
    (ri_flag && !cmd_en) |=> !ram_we); // R7
endmodule

bind rx_page_writer rx_page_writer_chk #(.PAGE_W(PAGE_W), .RAM_AW(RAM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .irq_mask(irq_mask), .cmd_en(cmd_en), .ram_we(ram_we),
  .ri_flag(ri_flag), .rx_irq(rx_irq)
);

// File: tb/test_rx_page_writer.sv
module test_rx_page_writer;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0;
  logic [7:0] in_data = 0;
  logic cfg_long_en = 0, irq_mask = 1, cmd_en = 0;
  logic [2:0] cmd_page = 0;
  logic ram_we, ri_flag, rx_irq;
  logic [10:0] ram_addr;
  logic [7:0] ram_wdata;

  int nchk = 0, nfail = 0, wcount = 0;
  logic [7:0] mem [0:2047];
  logic [7:0] pkt [$];

  always #2.5 clk = ~clk;

  rx_page_writer i_rx_page_writer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_data(in_data), .cfg_long_en(cfg_long_en), .irq_mask(irq_mask), .cmd_en(cmd_en),
    .cmd_page(cmd_page), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ri_flag(ri_flag), .rx_irq(rx_irq));

  always @(posedge clk) if (ram_we) begin
    mem[ram_addr] <= ram_wdata;
    wcount <= wcount + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dbyte(input logic [7:0] sid, input int i);
    return 8'(sid + i * 3);
  endfunction

  task automatic build(input logic [7:0] sid, did, input int n, input bit lng);
    pkt.delete();
    pkt.push_back(sid);
    pkt.push_back(did);
    if (lng) begin pkt.push_back(8'd0); pkt.push_back(8'(512 - n)); end
    else pkt.push_back(8'(256 - n));
    for (int i = 0; i < n; i++) pkt.push_back(dbyte(sid, i));
  endtask

  task automatic stream(input int cmd_at, input logic [2:0] cpg);
    for (int i = 0; i < pkt.size(); i++) begin
      @(negedge clk);
      in_valid = 1; in_data = pkt[i];
      in_sop = (i == 0); in_eop = (i == pkt.size() - 1);
      cmd_en = (i == cmd_at); cmd_page = cpg;
    end
    @(negedge clk);
    in_valid = 0; in_sop = 0; in_eop = 0; cmd_en = 0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic arm(input logic [2:0] pg);
    @(negedge clk); cmd_en = 1; cmd_page = pg;
    @(negedge clk); cmd_en = 0;
  endtask

  task automatic check_pkt(input int base, input logic [7:0] sid, did,
                           input int n, input bit lng, input string req);
    int bad = 0, first = 0;
    int cnt = lng ? 512 - n : 256 - n;
    check(mem[base] == sid && mem[base + 1] == did, req, mem[base + 1], did);
    if (lng) check(mem[base + 2] == 0 && mem[base + 3] == 8'(cnt), req, mem[base + 3], cnt);
    else check(mem[base + 2] == 8'(cnt), req, mem[base + 2], cnt);
    for (int i = 0; i < n; i++)
      if (mem[base + cnt + i] !== dbyte(sid, i)) begin
        if (bad == 0) first = i;
        bad++;
      end
    check(bad == 0, req, mem[base + cnt + first], dbyte(sid, first));
  endtask

  task automatic t_reset;
    check(ri_flag == 1, "R2 reset ri", ri_flag, 1);
    check(rx_irq == 1, "R1 irq at reset", rx_irq, 1);
    check(wcount == 0, "R3 no writes at reset", wcount, 0);
  endtask

  task automatic t_refuse;
    int w0 = wcount;
    build(8'h41, 8'h42, 6, 0);
    stream(-1, 0);
    check(wcount == w0, "R7 refused packet writes", wcount - w0, 0);
    check(ri_flag == 1, "R7 ri stays", ri_flag, 1);
  endtask

  task automatic t_short;
    arm(3'd2);
    check(ri_flag == 0, "R2 cmd clears ri", ri_flag, 0);
    check(rx_irq == 0, "R1 irq low", rx_irq, 0);
    build(8'h11, 8'h22, 5, 0);
    stream(-1, 0);
    check_pkt(512, 8'h11, 8'h22, 5, 0, "R3 R4 R6 short page2");
    check(ri_flag == 1, "R1 ri set", ri_flag, 1);
    check(rx_irq == 1, "R1 irq set", rx_irq, 1);
    irq_mask = 0; #1;
    check(rx_irq == 0, "R1 masked irq", rx_irq, 0);
    irq_mask = 1;
  endtask

  task automatic t_long;
    int w0;
    arm(3'd3);
    w0 = wcount;
    build(8'h33, 8'h44, 300, 1);
    stream(-1, 0);
    check(wcount - w0 == 2, "R5 long refused when disabled", wcount - w0, 2);
    check(ri_flag == 0, "R5 ri after refused long", ri_flag, 0);
    cfg_long_en = 1;
    arm(3'd1);
    build(8'h55, 8'h66, 300, 1);
    stream(-1, 0);
    check_pkt(512, 8'h55, 8'h66, 300, 1, "R5 R6 long page1");
    check(ri_flag == 1, "R5 long completes", ri_flag, 1);
    arm(3'd2);
    build(8'h77, 8'h88, 10, 0);
    stream(-1, 0);
    check_pkt(1024, 8'h77, 8'h88, 10, 0, "R4 R6 short in 512 page");
    arm(3'd0);
    w0 = wcount;
    build(8'h12, 8'h34, 6, 1);
    pkt[3] = 8'd3;
    stream(-1, 0);
    check(wcount - w0 == 3, "R5 second count below 4", wcount - w0, 3);
    check(ri_flag == 0, "R5 ri after bad count", ri_flag, 0);
    cfg_long_en = 0;
  endtask

  task automatic t_badcount;
    int w0 = wcount;
    build(8'h21, 8'h31, 4, 0);
    pkt[2] = 8'd2;
    stream(-1, 0);
    check(wcount - w0 == 2, "R4 count below 3", wcount - w0, 2);
    check(ri_flag == 0, "R4 ri after bad count", ri_flag, 0);
  endtask

  task automatic t_length;
    int w0 = wcount;
    build(8'h5a, 8'h5b, 5, 0);
    void'(pkt.pop_back());
    stream(-1, 0);
    check(ri_flag == 0, "R8 early end", ri_flag, 0);
    w0 = wcount;
    build(8'h6a, 8'h6b, 5, 0);
    pkt.push_back(8'hee);
    stream(-1, 0);
    check(wcount - w0 == 8, "R8 overflow byte not written", wcount - w0, 8);
    check(ri_flag == 0, "R8 overflow ri", ri_flag, 0);
  endtask

  task automatic t_midcmd;
    arm(3'd5);
    build(8'h91, 8'h92, 4, 0);
    stream(3, 3'd6);
    check_pkt(1280, 8'h91, 8'h92, 4, 0, "R9 page held during packet");
    check(ri_flag == 1, "R9 packet completes", ri_flag, 1);
  endtask

  task automatic t_collide;
    arm(3'd0);
    build(8'hA1, 8'hA2, 3, 0);
    stream(5, 3'd4);
    check(ri_flag == 1, "R10 completion wins", ri_flag, 1);
    check(rx_irq == 1, "R10 irq after collision", rx_irq, 1);
    check_pkt(0, 8'hA1, 8'hA2, 3, 0, "R10 data stored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_refuse();
    t_short();
    t_long();
    t_badcount();
    t_length();
    t_midcmd();
    t_collide();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule